// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block sits in each processor node that shares one external parallel bus with a host processor and at most one other peer node. It decides, cycle by cycle, who owns the bus: nobody, peer slot 1, peer slot 2 or the host. Every node runs an identical copy of the ownership state machine. Each copy sees only the shared request lines and the host request, so all copies reach the same verdict without a central arbiter. A node drives only the request line that its static ID selects, and it reads every line.

Shared open-drain lines (peer requests, core priority) are modelled with active-high signals. The value seen on a line is the OR of all node drives, which equals a wired-AND of active-low enables. The block has no data path. All pins are plain level controls, so none of them carries a valid/ready handshake or back-pressure.

The block's outputs are:
- the host grant;
- the node's own request drive;
- a bus-master status flag;
- an output enable for the address, data, select and strobe drivers;
- a separate enable for the SDRAM control pins, which never drops after reset;
- a go signal for the local access.

Top module: `xbus_owner_arb`

## Requirements
- R1: While `rst_n` is low, `bus_oe`, `host_gnt` and `req_drv` are 0, and `bus_master` is 0 unless `node_id` is 00. After reset the owner is nobody and no node drives the bus.
- R2: With `node_id`=01 the node drives only `req_drv[0]`, and with `node_id`=10 only `req_drv[1]`. With `node_id`=00 (single processor) it drives neither. The line is high while `need_bus` is high and the node is not backing off.
- R3: When nobody owns the bus and exactly one peer line is high, that peer becomes owner at the next edge. Every change of owner passes through one cycle in which nobody owns the bus and `bus_oe` is 0.
- R4: If both peer lines are high while nobody owns the bus, the peer that held the bus most recently loses. With no history, slot 1 wins.
- R5: The owning node drops its request line to yield only when another peer line or the host request is high and `xfer_busy` is low. While `xfer_busy` is high it keeps the bus.
- R6: The host request beats both peer lines. Once the owner has yielded and the turnaround cycle has passed, the host owns the bus and `bus_oe` is 0. `host_gnt` comes from the node that held the bus last; if no node has held it yet, the node in slot 1 or the single processor supplies it.
- R7: `host_gnt` stays high for as long as `host_req` stays high. It falls at the first edge after `host_req` falls.
- R8: `bus_master` is high only while this node owns the bus. With `node_id`=00 it is high at all times.
- R9: A non-owning node with `core_urgent` and `need_bus` high drives `cpa_drv`. An owning node that sees `cpa_in` high while `dma_only` is high yields even when `xfer_busy` is high.
- R10: `bus_oe` is 0 in the cycle after any cycle in which `suspend` is high. `acc_go` is 0 in every cycle in which `suspend` is high.
- R11: `sdram_oe` is 0 during reset and 1 from the first edge after reset, regardless of host ownership or `suspend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_id | input | 2 | Static ID: 00 single, 01 slot 1, 10 slot 2 |
| host_req | input | 1 | Host asks for the bus |
| peer_req_in | input | 2 | Observed shared request lines (OR of all drives) |
| cpa_in | input | 1 | Observed shared core-priority line |
| need_bus | input | 1 | Local side wants the external bus |
| xfer_busy | input | 1 | Local access in progress (not at a transfer boundary) |
| dma_only | input | 1 | Current local traffic is background DMA |
| core_urgent | input | 1 | Local core needs the bus ahead of remote DMA |
| suspend | input | 1 | Suspend-bus request |
| req_drv | output | 2 | This node's drive onto the request lines |
| cpa_drv | output | 1 | This node's drive onto the core-priority line |
| host_gnt | output | 1 | Grant to the host |
| bus_master | output | 1 | This node is master |
| bus_oe | output | 1 | Enable for address, data, select and strobe drivers |
| sdram_oe | output | 1 | Enable for SDRAM control drivers |
| acc_go | output | 1 | Local access may proceed this cycle |

## Verification
A yield triggered by the host request can meet a yield triggered by a waiting peer, and a core-priority pre-emption can land in the middle of a busy transfer. The vector walk puts the host request and `xfer_busy` in the same cycle on the owning node, and puts `cpa_in` together with `xfer_busy` and `dma_only` in another. The bench then judges, edge by edge, when the request line drops, when the owner turns to nobody, and whether the grant goes to the host or to the waiting peer. Suspend is also raised while the node owns the bus, to confirm that `bus_oe` drops one cycle later while `bus_master` and `sdram_oe` stay high.

// File: rtl/xba_pkg.sv
package xba_pkg;
  localparam int LINES = 2;
  localparam int ID_W  = 2;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_P1   = 2'd1,
    OWN_P2   = 2'd2,
    OWN_HOST = 2'd3
  } own_t;
endpackage

// File: rtl/xba_owner_fsm.sv
// Shared ownership state; every node computes the same sequence from the lines.
module xba_owner_fsm
  import xba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic [LINES-1:0] lines,
  output own_t             cur,
  output own_t             last
);
  own_t nxt, last_nxt;

  always_comb begin
    nxt      = cur;
    last_nxt = last;
    case (cur)
      OWN_NONE: begin
        if (host_req)                nxt = OWN_HOST;
        else if (lines[0] && lines[1]) nxt = (last == OWN_P1) ? OWN_P2 : OWN_P1;
        else if (lines[0])           nxt = OWN_P1;
        else if (lines[1])           nxt = OWN_P2;
      end
      OWN_P1:   if (!lines[0]) nxt = OWN_NONE;
      OWN_P2:   if (!lines[1]) nxt = OWN_NONE;
      default:  if (!host_req) nxt = OWN_NONE;
    endcase
    if (nxt == OWN_P1 || nxt == OWN_P2) last_nxt = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= OWN_NONE;
      last <= OWN_NONE;
    end else begin
      cur  <= nxt;
      last <= last_nxt;
    end
  end
endmodule

// File: rtl/xba_yield.sv
// Decides when the owning node withdraws its request so the bus can move on.
module xba_yield
  import xba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  own_t cur,
  input  own_t self_own,
  input  logic is_owner,
  input  logic host_req,
  input  logic other_line,
  input  logic xfer_busy,
  input  logic cpa_in,
  input  logic dma_only,
  output logic backoff
);
  logic boundary_yield, preempt, clear_now;

  assign boundary_yield = (host_req || other_line) && !xfer_busy;
  assign preempt        = cpa_in && dma_only;
  assign clear_now      = (cur == OWN_NONE && !host_req && !other_line) ||
                          (cur != OWN_NONE && cur != self_own);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     backoff <= 1'b0;
    else if (is_owner && (boundary_yield || preempt)) backoff <= 1'b1;
    else if (clear_now)                             backoff <= 1'b0;
  end
endmodule

// File: rtl/xba_drive_ctl.sv
// Output enables, suspend register and host-grant ownership.
module xba_drive_ctl
  import xba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  own_t cur,
  input  own_t last,
  input  own_t self_own,
  input  logic is_owner,
  input  logic suspend,
  output logic bus_oe,
  output logic sdram_oe,
  output logic host_gnt
);
  logic susp_q, alive_q, granter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q  <= 1'b0;
      alive_q <= 1'b0;
    end else begin
      susp_q  <= suspend;
      alive_q <= 1'b1;
    end
  end

  assign granter  = (last == self_own && self_own != OWN_NONE) ||
                    (last == OWN_NONE && self_own == OWN_P1);
  assign host_gnt = (cur == OWN_HOST) && granter;
  assign bus_oe   = is_owner && !susp_q;
  assign sdram_oe = alive_q;
endmodule

// File: rtl/xbus_owner_arb.sv
module xbus_owner_arb
  import xba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  node_id,
  input  logic             host_req,
  input  logic [LINES-1:0] peer_req_in,
  input  logic             cpa_in,
  input  logic             need_bus,
  input  logic             xfer_busy,
  input  logic             dma_only,
  input  logic             core_urgent,
  input  logic             suspend,
  output logic [LINES-1:0] req_drv,
  output logic             cpa_drv,
  output logic             host_gnt,
  output logic             bus_master,
  output logic             bus_oe,
  output logic             sdram_oe,
  output logic             acc_go
);
  localparam logic [ID_W-1:0] ID_SOLO = '0;
  localparam logic [ID_W-1:0] ID_BAD  = '1;

  own_t             cur, last, self_own;
  logic             solo, id_ok, is_owner, backoff, line_drive, other_line;
  logic [LINES-1:0] own_mask, eff_lines;

  assign solo  = (node_id == ID_SOLO);
  assign id_ok = (node_id != ID_BAD);

  always_comb begin
    case (node_id)
      2'b00, 2'b01: self_own = OWN_P1;
      2'b10:        self_own = OWN_P2;
      default:      self_own = OWN_NONE;
    endcase
  end

  assign line_drive = sdram_oe && id_ok && !solo && need_bus && !backoff;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign own_mask[k] = (node_id == ID_W'(k + 1));
    assign req_drv[k]  = line_drive && own_mask[k];
  end

  // A single processor sees a private virtual request on slot 1.
  assign eff_lines  = solo ? {{(LINES-1){1'b0}}, !backoff} : peer_req_in;
  assign other_line = !solo && |(peer_req_in & ~own_mask);

  xba_owner_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .lines    (eff_lines),
    .cur      (cur),
    .last     (last)
  );

  assign is_owner = id_ok && (cur == self_own);

  xba_yield u_yield (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur        (cur),
    .self_own   (self_own),
    .is_owner   (is_owner),
    .host_req   (host_req),
    .other_line (other_line),
    .xfer_busy  (xfer_busy),
    .cpa_in     (cpa_in),
    .dma_only   (dma_only),
    .backoff    (backoff)
  );

  xba_drive_ctl u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (cur),
    .last     (last),
    .self_own (self_own),
    .is_owner (is_owner),
    .suspend  (suspend),
    .bus_oe   (bus_oe),
    .sdram_oe (sdram_oe),
    .host_gnt (host_gnt)
  );

  assign bus_master = solo || is_owner;
  assign cpa_drv    = sdram_oe && id_ok && !solo && core_urgent && need_bus && !is_owner;
  assign acc_go     = need_bus && is_owner && !suspend;
endmodule

// File: rtl/xba_checker.sv
module xba_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_req,
  input logic       suspend,
  input logic       host_gnt,
  input logic       bus_oe,
  input logic       bus_master,
  input logic       sdram_oe,
  input logic       acc_go
);
  p_oe_only_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_master);

  p_host_excludes_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> !bus_oe);

  p_gnt_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && host_req) |=> host_gnt);

  p_gnt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !host_req) |=> !host_gnt);

  p_suspend_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> !bus_oe);

  p_suspend_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> !acc_go);

  p_sdram_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_oe |=> sdram_oe);
endmodule

bind xbus_owner_arb xba_checker i_xba_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_req   (host_req),
  .suspend    (suspend),
  .host_gnt   (host_gnt),
  .bus_oe     (bus_oe),
  .bus_master (bus_master),
  .sdram_oe   (sdram_oe),
  .acc_go     (acc_go)
);

// File: tb/test_xbus_owner_arb.sv
module test_xbus_owner_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] node_id = 2'b01;
  logic       host_req = 0, need_bus = 0, xfer_busy = 0, dma_only = 0;
  logic       core_urgent = 0, suspend = 0, ext_cpa = 0;
  logic [1:0] ext_req = 2'b00;
  logic [1:0] req_drv, peer_req_in;
  logic       cpa_drv, cpa_in, host_gnt, bus_master, bus_oe, sdram_oe, acc_go;
  int         n_cmp = 0, n_bad = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  // Wired lines: the other peer's drive ORed with ours.
  assign peer_req_in = req_drv | ext_req;
  assign cpa_in      = cpa_drv | ext_cpa;

  xbus_owner_arb i_xbus_owner_arb (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .host_req(host_req),
    .peer_req_in(peer_req_in), .cpa_in(cpa_in), .need_bus(need_bus),
    .xfer_busy(xfer_busy), .dma_only(dma_only), .core_urgent(core_urgent),
    .suspend(suspend), .req_drv(req_drv), .cpa_drv(cpa_drv),
    .host_gnt(host_gnt), .bus_master(bus_master), .bus_oe(bus_oe),
    .sdram_oe(sdram_oe), .acc_go(acc_go)
  );

  // inputs: host ext[1:0] need busy dma urgent xcpa susp | expected: oe bm gnt req[1:0] cpa
  localparam int NV = 27;
  localparam logic [14:0] VEC [NV] = '{
    {9'b0_00_1_0_0_0_0_0, 6'b1_1_0_01_0},
    {9'b0_10_1_1_0_0_0_0, 6'b1_1_0_01_0},
    {9'b0_10_1_0_0_0_0_0, 6'b1_1_0_00_0},
    {9'b0_10_1_0_0_0_0_0, 6'b0_0_0_00_0},
    {9'b0_10_1_0_0_0_0_0, 6'b0_0_0_00_0},
    {9'b0_10_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_10_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b1_1_0_01_0},
    {9'b0_00_0_0_0_0_0_0, 6'b0_0_0_00_0},
    {9'b0_10_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_10_1_0_0_0_0_0, 6'b1_1_0_01_0},
    {9'b1_00_1_1_0_0_0_0, 6'b1_1_0_01_0},
    {9'b1_00_1_0_0_0_0_0, 6'b1_1_0_00_0},
    {9'b1_00_1_0_0_0_0_0, 6'b0_0_0_00_0},
    {9'b1_00_1_0_0_0_0_0, 6'b0_0_1_00_0},
    {9'b1_00_1_0_0_0_0_0, 6'b0_0_1_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b1_1_0_01_0},
    {9'b0_10_1_1_1_0_1_0, 6'b1_1_0_00_0},
    {9'b0_10_1_1_1_0_1_0, 6'b0_0_0_00_0},
    {9'b0_10_1_0_0_1_0_0, 6'b0_0_0_00_1},
    {9'b0_00_1_0_0_0_0_0, 6'b0_0_0_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b1_1_0_01_0},
    {9'b0_00_1_0_0_0_0_1, 6'b0_1_0_01_0},
    {9'b0_00_1_0_0_0_0_0, 6'b1_1_0_01_0}
  };

  function automatic string row_tag(int i);
    if (i == 0)       return "R3 first owner";
    else if (i <= 1)  return "R5 busy keeps bus";
    else if (i <= 7)  return "R5 yield and R3 turnaround";
    else if (i <= 8)  return "R3 re-acquire";
    else if (i <= 12) return "R4 rotation";
    else if (i <= 15) return "R6 host yield";
    else if (i <= 17) return "R6 host owns";
    else if (i <= 19) return "R7 host release";
    else if (i <= 21) return "R9 preempt";
    else if (i <= 22) return "R9 cpa drive";
    else if (i <= 24) return "R3 back to owner";
    else              return "R10 suspend";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic idle_inputs();
    host_req = 0; need_bus = 0; xfer_busy = 0; dma_only = 0;
    core_urgent = 0; suspend = 0; ext_cpa = 0; ext_req = 2'b00;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 and R11: reset state with a pending request
    idle_inputs();
    node_id = 2'b01; need_bus = 1; rst_n = 0;
    tick(2);
    check("R1 reset outputs oe,gnt,bm,req", {3'b0, bus_oe, host_gnt, bus_master, req_drv},
          8'b0);
    check("R11 sdram_oe low in reset", {7'b0, sdram_oe}, 8'b0);
    need_bus = 0;
    rst_n = 1;
    tick(2);
    check("R11 sdram_oe after reset", {7'b0, sdram_oe}, 8'b1);
    check("R1 nobody owns after reset", {6'b0, bus_oe, bus_master}, 8'b0);

    // vector walk, node in slot 1
    for (int i = 0; i < NV; i++) begin
      {host_req, ext_req, need_bus, xfer_busy, dma_only, core_urgent, ext_cpa, suspend} =
        VEC[i][14:6];
      tick(1);
      check(row_tag(i), {2'b0, bus_oe, bus_master, host_gnt, req_drv, cpa_drv},
            {2'b0, VEC[i][5:0]});
    end
    check("R11 sdram_oe held", {7'b0, sdram_oe}, 8'b1);

    // R2: slot 2 drives only its own line
    idle_inputs();
    rst_n = 0; node_id = 2'b10;
    tick(1);
    rst_n = 1; need_bus = 1;
    tick(1);
    check("R2 slot2 line", {6'b0, req_drv}, 8'b10);
    tick(1);
    check("R8 slot2 master", {6'b0, bus_master, bus_oe}, 8'b11);

    // R8 / R6 / R7 / R10 on a single processor
    idle_inputs();
    rst_n = 0; node_id = 2'b00;
    tick(1);
    check("R8 solo master in reset", {7'b0, bus_master}, 8'b1);
    rst_n = 1; need_bus = 1;
    tick(1);
    check("R2 solo drives no line", {6'b0, req_drv}, 8'b0);
    check("R8 solo owns", {6'b0, bus_master, bus_oe}, 8'b11);
    suspend = 1;
    #1;
    check("R10 acc_go stalled", {7'b0, acc_go}, 8'b0);
    tick(1);
    check("R10 oe off after suspend", {6'b0, bus_oe, sdram_oe}, 8'b01);
    suspend = 0;
    tick(1);
    check("R10 resume", {6'b0, bus_oe, acc_go}, 8'b11);
    host_req = 1;
    tick(3);
    check("R6 solo host grant", {5'b0, host_gnt, bus_oe, bus_master}, 8'b101);
    check("R11 sdram_oe during host", {7'b0, sdram_oe}, 8'b1);
    host_req = 0;
    tick(1);
    check("R7 grant drops", {7'b0, host_gnt}, 8'b0);
    tick(2);
    check("R3 solo regains bus", {7'b0, bus_oe}, 8'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule